// File: doc/BRIEF.md
# Vector register load/store address unit

This block decodes one 32-bit instruction word from the scalar vector-register load/store group. From that word it builds the memory request and the base-register update. The surrounding pipeline gives it the word, a valid strobe, the current 64-bit value of the base register and an enable for floating-point/vector use. One cycle later the block returns a registered result:
- a request (effective address, access scale, direction, target register index) together with a base writeback value, or
- exactly one of four outcomes: undefined encoding, disabled-unit trap, stack-pointer misalignment, or "not mine" for words outside the group.

Three addressing forms share one datapath:
- **Post-index** accesses the unchanged base and writes back base plus a signed 9-bit byte offset.
- **Pre-index** adds the signed offset first, accesses that sum and writes the same sum back.
- **Unsigned-offset** adds a 12-bit immediate scaled by the access size and performs no writeback.

Base index 31 names the stack pointer, which must be 16-byte aligned.

Top module: `vls_addr_unit`

## Requirements
- R1: Every result output is registered. `out_valid` is high in the cycle after a cycle with `instr_valid` high. While `out_valid` is low, every other output is zero.
- R2: A word belongs to the group only if it meets all of the following: bits 29:27 = 111, bit 26 = 1, bit 25 = 0, and either bit 24 = 1, or bit 24 = 0 with bit 21 = 0 and bit 10 = 1. Any other valid word raises only `not_mine`.
- R3: The scale is {bit 23, bits 31:30}. A scale above 4 raises `undef_flag` with no request and no writeback. This outcome takes priority over the trap.
- R4: With `fp_enable` low, a defined group word raises `trap_flag` with no request and no writeback.
- R5: When bits 9:5 = 31 and the base value has any of its low 4 bits set, an enabled, defined word raises `align_fault` with no request and no writeback.
- R6: At most one of `not_mine`, `undef_flag`, `trap_flag` and `align_fault` is high. `mem_req` is high only when none of them is.
- R7: Post-index (bit 24 = 0, bits 11:10 = 01): the address is the base. `wb_en` is high and `wb_value` is base plus the sign-extended bits 20:12.
- R8: Pre-index (bit 24 = 0, bits 11:10 = 11): the address and `wb_value` are both base plus the sign-extended bits 20:12, and `wb_en` is high.
- R9: Unsigned offset (bit 24 = 1): the address is base plus bits 21:10 shifted left by the scale. `wb_en` and `wb_value` are zero.
- R10: On a request, `mem_scale` equals the scale (access width is 8 << scale bits), `mem_is_load` equals bit 22 (1 = load), and `tgt_reg` equals bits 4:0.
- R11: `wb_to_sp` is high exactly when `wb_en` is high and the base index is 31.
- R12: `tag_check` is high on a request when writeback is enabled or the base index is not 31.
- R13: All address and writeback sums wrap modulo 2^64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is present this cycle |
| instr_word | input | 32 | Instruction word |
| base_value | input | 64 | Value of the general register or stack pointer selected by bits 9:5 |
| fp_enable | input | 1 | Vector/floating-point unit enabled |
| out_valid | output | 1 | Registered result is present |
| not_mine | output | 1 | Word is outside this group |
| mem_req | output | 1 | Memory access is issued |
| mem_addr | output | 64 | Effective byte address |
| mem_scale | output | 3 | Log2 of access size in bytes |
| mem_is_load | output | 1 | 1 = load, 0 = store |
| tgt_reg | output | 5 | Vector register index |
| wb_en | output | 1 | Base register writeback |
| wb_value | output | 64 | New base value |
| wb_to_sp | output | 1 | Writeback goes to the stack pointer |
| tag_check | output | 1 | Access is subject to tag checking |
| undef_flag | output | 1 | Reserved scale |
| trap_flag | output | 1 | Unit disabled |
| align_fault | output | 1 | Stack pointer misaligned |

## Verification
The assertions assume that `instr_word`, `base_value` and `fp_enable` are stable and meaningful whenever `instr_valid` is high. They also assume that `base_value` already reflects the register named by bits 9:5, because the block cannot see the register file. The bench drives all inputs on the falling edge and pulses `instr_valid` for one cycle per word. It sets the base value explicitly for every word, including the stack-pointer cases, and idles between words so that each result can be matched to the word that produced it.

// File: rtl/vls_pkg.sv
package vls_pkg;

  localparam int VLS_AW = 64;

  typedef enum logic [1:0] {
    FORM_NONE = 2'd0,
    FORM_POST = 2'd1,
    FORM_PRE  = 2'd2,
    FORM_UOFF = 2'd3
  } form_e;

  typedef struct packed {
    logic        hit;
    form_e       form;
    logic [2:0]  scale;
    logic        is_load;
    logic [4:0]  rn;
    logic [4:0]  rt;
    logic [8:0]  imm9;
    logic [11:0] imm12;
  } dec_s;

  // signed 9-bit byte offset widened to the address width
  function automatic logic [VLS_AW-1:0] widen_imm9(input logic [8:0] v);
    widen_imm9 = {{(VLS_AW-9){v[8]}}, v};
  endfunction

  // 12-bit unsigned immediate multiplied by the access size
  function automatic logic [VLS_AW-1:0] scale_imm12(input logic [11:0] v,
                                                    input logic [2:0]  sc);
    logic [VLS_AW-1:0] z;
    z = {{(VLS_AW-12){1'b0}}, v};
    scale_imm12 = z << sc;
  endfunction

endpackage

// File: rtl/vls_decode.sv
module vls_decode
  import vls_pkg::*;
#(
  parameter int IW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] instr,
  output dec_s          dec
);

  logic group_bits;
  logic idx_ok;
  logic hit_w;

  assign group_bits = (instr[29:27] == 3'b111) && instr[26] && !instr[25];
  assign idx_ok     = !instr[24] && !instr[21] && instr[10];
  assign hit_w      = group_bits && (instr[24] || idx_ok);

  always_comb begin
    dec.hit     = hit_w;
    dec.scale   = {instr[23], instr[31:30]};
    dec.is_load = instr[22];
    dec.rn      = instr[9:5];
    dec.rt      = instr[4:0];
    dec.imm9    = instr[20:12];
    dec.imm12   = instr[21:10];
    if (!hit_w)         dec.form = FORM_NONE;
    else if (instr[24]) dec.form = FORM_UOFF;
    else if (instr[11]) dec.form = FORM_PRE;
    else                dec.form = FORM_POST;
  end

  // R2: a recognised word never decodes to the empty form
  assert_form_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dec.hit |-> dec.form != FORM_NONE);

endmodule

// File: rtl/vls_agen.sv
module vls_agen
  import vls_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dec_s          dec,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] new_base,
  output logic          wants_wb
);

  logic [AW-1:0] offset;
  logic [AW-1:0] sum;
  logic [VLS_AW-1:0] off_full;

  always_comb begin
    if (dec.form == FORM_UOFF) off_full = scale_imm12(dec.imm12, dec.scale);
    else                       off_full = widen_imm9(dec.imm9);
  end

  assign offset   = off_full[AW-1:0];
  assign sum      = base + offset;            // R13: wraps naturally
  assign eff_addr = (dec.form == FORM_POST) ? base : sum;
  assign new_base = sum;
  assign wants_wb = (dec.form == FORM_POST) || (dec.form == FORM_PRE);

  // R7: post-index touches the untouched base
  assert_post_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.form == FORM_POST) |-> eff_addr == base);
  // R8: pre-index accesses the value it writes back
  assert_pre_same_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.form == FORM_PRE) |-> eff_addr == new_base);

endmodule

// File: rtl/vls_guard.sv
module vls_guard
  import vls_pkg::*;
#(
  parameter int AW            = 64,
  parameter int MAX_SCALE     = 4,
  parameter int SP_ALIGN_BITS = 4,
  parameter int SP_INDEX      = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dec_s          dec,
  input  logic [AW-1:0] base,
  input  logic          fp_en,
  output logic          undef_w,
  output logic          trap_w,
  output logic          align_w,
  output logic          go_w
);

  logic uses_sp;
  logic misaligned;

  assign uses_sp    = (dec.rn == 5'(SP_INDEX));
  assign misaligned = |base[SP_ALIGN_BITS-1:0];

  assign undef_w = dec.hit && (int'(dec.scale) > MAX_SCALE);
  assign trap_w  = dec.hit && !undef_w && !fp_en;
  assign align_w = dec.hit && !undef_w && fp_en && uses_sp && misaligned;
  assign go_w    = dec.hit && !undef_w && !trap_w && !align_w;

  // R6: fault causes are mutually exclusive and block the request
  assert_one_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({undef_w, trap_w, align_w, go_w}) <= 1);
  // R3: undefined wins over a disabled unit
  assert_undef_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.hit && !fp_en && int'(dec.scale) > MAX_SCALE) |-> undef_w && !trap_w);

endmodule

// File: rtl/vls_addr_unit.sv
module vls_addr_unit
  import vls_pkg::*;
#(
  parameter int IW            = 32,
  parameter int AW            = 64,
  parameter int RW            = 5,
  parameter int SW            = 3,
  parameter int MAX_SCALE     = 4,
  parameter int SP_ALIGN_BITS = 4,
  parameter int SP_INDEX      = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [IW-1:0] instr_word,
  input  logic [AW-1:0] base_value,
  input  logic          fp_enable,
  output logic          out_valid,
  output logic          not_mine,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [SW-1:0] mem_scale,
  output logic          mem_is_load,
  output logic [RW-1:0] tgt_reg,
  output logic          wb_en,
  output logic [AW-1:0] wb_value,
  output logic          wb_to_sp,
  output logic          tag_check,
  output logic          undef_flag,
  output logic          trap_flag,
  output logic          align_fault
);

  dec_s          dec;
  logic [AW-1:0] eff_addr;
  logic [AW-1:0] new_base;
  logic          wants_wb;
  logic          undef_w, trap_w, align_w, go_w;
  logic          fire;
  logic          base_is_sp;

  vls_decode #(.IW(IW)) u_decode (
    .clk(clk), .rst_n(rst_n), .instr(instr_word), .dec(dec)
  );

  vls_agen #(.AW(AW)) u_agen (
    .clk(clk), .rst_n(rst_n), .dec(dec), .base(base_value),
    .eff_addr(eff_addr), .new_base(new_base), .wants_wb(wants_wb)
  );

  vls_guard #(
    .AW(AW), .MAX_SCALE(MAX_SCALE),
    .SP_ALIGN_BITS(SP_ALIGN_BITS), .SP_INDEX(SP_INDEX)
  ) u_guard (
    .clk(clk), .rst_n(rst_n), .dec(dec), .base(base_value), .fp_en(fp_enable),
    .undef_w(undef_w), .trap_w(trap_w), .align_w(align_w), .go_w(go_w)
  );

  assign fire       = instr_valid && go_w;
  assign base_is_sp = (dec.rn == 5'(SP_INDEX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      not_mine    <= 1'b0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      mem_scale   <= '0;
      mem_is_load <= 1'b0;
      tgt_reg     <= '0;
      wb_en       <= 1'b0;
      wb_value    <= '0;
      wb_to_sp    <= 1'b0;
      tag_check   <= 1'b0;
      undef_flag  <= 1'b0;
      trap_flag   <= 1'b0;
      align_fault <= 1'b0;
    end else begin
      out_valid   <= instr_valid;
      not_mine    <= instr_valid && !dec.hit;
      undef_flag  <= instr_valid && undef_w;
      trap_flag   <= instr_valid && trap_w;
      align_fault <= instr_valid && align_w;
      mem_req     <= fire;
      mem_addr    <= fire ? eff_addr : '0;
      mem_scale   <= fire ? SW'(dec.scale) : '0;
      mem_is_load <= fire && dec.is_load;
      tgt_reg     <= fire ? RW'(dec.rt) : '0;
      wb_en       <= fire && wants_wb;
      wb_value    <= (fire && wants_wb) ? new_base : '0;
      wb_to_sp    <= fire && wants_wb && base_is_sp;
      tag_check   <= fire && (wants_wb || !base_is_sp);
    end
  end

  // R1: one-cycle registered result
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid |=> out_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(not_mine || mem_req || wb_en || undef_flag || trap_flag ||
                     align_fault || tag_check || wb_to_sp));
  // R2: foreign words raise nothing else
  assert_foreign_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    not_mine |-> !(mem_req || wb_en || undef_flag || trap_flag || align_fault));
  // R3, R4, R5: faults suppress the access and the writeback
  assert_undef_noreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |-> !mem_req && !wb_en);
  assert_trap_noreq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_flag |-> !mem_req && !wb_en);
  assert_align_noreq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    align_fault |-> !mem_req && !wb_en);
  // R11: stack pointer writeback implies writeback
  assert_sp_wb_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_to_sp |-> wb_en && mem_req);
  // R12: an unchecked access is a stack-based access without writeback
  assert_tag_gap_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !tag_check) |-> !wb_en);

endmodule

// File: tb/vls_addr_unit_tb.sv
module vls_addr_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic [63:0] base_value = '0;
  logic        fp_enable = 1'b1;
  logic        out_valid, not_mine, mem_req, mem_is_load, wb_en, wb_to_sp;
  logic        tag_check, undef_flag, trap_flag, align_fault;
  logic [63:0] mem_addr, wb_value;
  logic [2:0]  mem_scale;
  logic [4:0]  tgt_reg;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vls_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .base_value(base_value), .fp_enable(fp_enable), .out_valid(out_valid),
    .not_mine(not_mine), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_scale(mem_scale), .mem_is_load(mem_is_load), .tgt_reg(tgt_reg),
    .wb_en(wb_en), .wb_value(wb_value), .wb_to_sp(wb_to_sp),
    .tag_check(tag_check), .undef_flag(undef_flag), .trap_flag(trap_flag),
    .align_fault(align_fault)
  );

  // expected values
  logic        x_nm, x_req, x_load, x_wb, x_sp, x_tag, x_und, x_trap, x_al;
  logic [63:0] x_addr, x_wbv;
  logic [2:0]  x_sc;
  logic [4:0]  x_tgt;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_idx(input int sz, input int opc, input int simm,
                                         input bit pre, input int rn, input int rt);
    logic [8:0] i9;
    i9 = 9'(simm);
    return {2'(sz), 3'b111, 1'b1, 2'b00, 2'(opc), 1'b0, i9, pre, 1'b1, 5'(rn), 5'(rt)};
  endfunction

  function automatic logic [31:0] mk_uns(input int sz, input int opc, input int u12,
                                         input int rn, input int rt);
    return {2'(sz), 3'b111, 1'b1, 2'b01, 2'(opc), 12'(u12), 5'(rn), 5'(rt)};
  endfunction

  // reference: computed from the requirements with integer arithmetic
  task automatic model(input logic [31:0] w, input logic [63:0] b, input bit fp);
    bit grp;
    int sc, rn, s9;
    longint unsigned off, total;
    bit uo, post;
    grp = (w[29:27] == 3'd7) && w[26] && !w[25] &&
          (w[24] || (!w[21] && w[10]));
    sc = w[23] * 4 + w[31:30];
    rn = w[9:5];
    {x_nm, x_req, x_load, x_wb, x_sp, x_tag, x_und, x_trap, x_al} = '0;
    x_addr = 0; x_wbv = 0; x_sc = 0; x_tgt = 0;
    if (!grp) x_nm = 1;
    else if (sc > 4) x_und = 1;
    else if (!fp) x_trap = 1;
    else if (rn == 31 && (b % 16) != 0) x_al = 1;
    else begin
      uo = w[24];
      post = !uo && !w[11];
      if (uo) off = longint'(w[21:10]) * (longint'(1) << sc);
      else begin
        s9 = w[20:12];
        if (s9 >= 256) s9 -= 512;
        off = longint'(s9);
      end
      total = b + off;
      x_req = 1; x_sc = 3'(sc); x_load = w[22]; x_tgt = w[4:0];
      x_addr = post ? b : total;
      x_wb = !uo; x_wbv = uo ? 64'd0 : total;
      x_sp = x_wb && rn == 31;
      x_tag = x_wb || rn != 31;
    end
  endtask

  task automatic run(input string atag, input logic [31:0] w,
                     input logic [63:0] b, input bit fp);
    model(w, b, fp);
    @(negedge clk);
    instr_word = w; base_value = b; fp_enable = fp; instr_valid = 1;
    @(negedge clk);
    instr_valid = 0;
    chk("R1", "out_valid", 64'(out_valid), 1);
    chk("R2", "not_mine", 64'(not_mine), 64'(x_nm));
    chk("R3", "undef", 64'(undef_flag), 64'(x_und));
    chk("R4", "trap", 64'(trap_flag), 64'(x_trap));
    chk("R5", "align", 64'(align_fault), 64'(x_al));
    chk("R6", "mem_req", 64'(mem_req), 64'(x_req));
    chk(atag, "mem_addr", mem_addr, x_addr);
    chk(atag, "wb_en", 64'(wb_en), 64'(x_wb));
    chk(atag, "wb_value", wb_value, x_wbv);
    chk("R10", "scale", 64'(mem_scale), 64'(x_sc));
    chk("R10", "is_load", 64'(mem_is_load), 64'(x_load));
    chk("R10", "tgt", 64'(tgt_reg), 64'(x_tgt));
    chk("R11", "wb_to_sp", 64'(wb_to_sp), 64'(x_sp));
    chk("R12", "tag_check", 64'(tag_check), 64'(x_tag));
    @(negedge clk);
    chk("R1", "idle out_valid", 64'(out_valid), 0);
    chk("R1", "idle mem_req", 64'(mem_req), 0);
  endtask

  task automatic t_reset;
    chk("R1", "reset out_valid", 64'(out_valid), 0);
    chk("R1", "reset mem_req", 64'(mem_req), 0);
    chk("R1", "reset wb_en", 64'(wb_en), 0);
  endtask

  task automatic t_post_R7;
    for (int sc = 0; sc <= 4; sc++) begin
      run("R7", mk_idx(sc % 4, (sc / 4) * 2 + 1, -256, 0, 3, 7), 64'h1000, 1);
      run("R7", mk_idx(sc % 4, (sc / 4) * 2, 255, 0, 12, 30), 64'h2000_0000, 1);
    end
  endtask

  task automatic t_pre_R8;
    for (int sc = 0; sc <= 4; sc++) begin
      run("R8", mk_idx(sc % 4, (sc / 4) * 2 + 1, 255, 1, 1, 2), 64'h400, 1);
      run("R8", mk_idx(sc % 4, (sc / 4) * 2, -256, 1, 0, 31), 64'h400, 1);
    end
    run("R8", mk_idx(3, 1, 0, 1, 8, 9), 64'h55AA, 1);
  endtask

  task automatic t_uoff_R9;
    for (int sc = 0; sc <= 4; sc++) begin
      run("R9", mk_uns(sc % 4, (sc / 4) * 2 + 1, 4095, 4, 5), 64'h10_0000, 1);
      run("R9", mk_uns(sc % 4, (sc / 4) * 2, 1, 6, 17), 64'h10_0000, 1);
    end
  endtask

  task automatic t_undef_R3;
    for (int sz = 1; sz <= 3; sz++) run("R3", mk_idx(sz, 3, 4, 1, 2, 2), 64'h100, 1);
    run("R3", mk_uns(2, 2, 7, 1, 1), 64'h100, 0);  // undefined beats trap
  endtask

  task automatic t_trap_R4;
    run("R4", mk_idx(2, 1, 8, 0, 2, 2), 64'h100, 0);
    run("R4", mk_uns(0, 0, 1, 31, 3), 64'h3, 0);   // trap beats alignment
  endtask

  task automatic t_sp_R5_R11_R12;
    run("R5", mk_idx(3, 1, 16, 1, 31, 4), 64'h108, 1);
    run("R5", mk_uns(1, 1, 2, 31, 4), 64'h101, 1);
    run("R11", mk_idx(3, 0, -16, 1, 31, 4), 64'h1000, 1);
    run("R11", mk_idx(2, 1, 32, 0, 31, 4), 64'hFF0, 1);
    run("R12", mk_uns(3, 1, 5, 31, 4), 64'h2000, 1);
  endtask

  task automatic t_foreign_R2;
    logic [31:0] w;
    w = mk_idx(2, 1, 4, 1, 1, 1);
    run("R2", w & ~32'h0400_0000, 64'h10, 1);      // bit 26 clear
    run("R2", w | 32'h0020_0000, 64'h10, 1);       // bit 21 set
    run("R2", w & ~32'h0000_0C00, 64'h10, 1);      // bits 11:10 = 00
    run("R2", w | 32'h0200_0000, 64'h10, 1);       // bit 25 set
    run("R2", 32'h0, 64'h10, 1);
  endtask

  task automatic t_wrap_R13;
    run("R13", mk_idx(0, 1, 255, 1, 2, 3), 64'hFFFF_FFFF_FFFF_FFF0, 1);
    run("R13", mk_idx(0, 1, -256, 0, 2, 3), 64'h5, 1);
    run("R13", mk_uns(3, 1, 4095, 2, 3), 64'hFFFF_FFFF_FFFF_8000, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_post_R7();
    t_pre_R8();
    t_uoff_R9();
    t_undef_R3();
    t_trap_R4();
    t_sp_R5_R11_R12();
    t_foreign_R2();
    t_wrap_R13();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule